// File: doc/BRIEF.md
# Register-Mapped SPI Master Controller

This block is an SPI master that a processor drives through a small register bus of 32-bit words. Software enables the block, writes a byte to the data register and polls the status register. The block then shifts the byte out on MOSI while it clocks a byte in from MISO. Once the exchange has finished, software reads the received byte back from the same data register offset.

The register window holds nine words. Two control words are stored and read back, along with a status word and a data word. The rest are compatibility words: one polynomial word, two checksum result words and two audio-mode configuration words. These read as their reset values and ignore writes. The serial side runs SPI mode 0 with 8-bit frames, most significant bit first. SCK runs at the system clock divided by `CLK_DIV`.

Top module: `spi_master_ctrl`

## Requirements
- R1: After reset the byte offsets read as follows: 0x00 and 0x04 (control words) read 0. 0x08 (status) reads 0x0000000A. 0x0C (data) reads 0x0000000C. 0x10 (polynomial) reads 0x00000007. 0x14 and 0x18 (checksum results) read 0. 0x1C (audio config) reads 0. 0x20 (audio divider) reads 0x00000002.
- R2: Words written to offsets 0x00 and 0x04 read back unchanged. In the word at 0x00, bit 6 is enable and bit 2 is master select.
- R3: Writes to offsets 0x08, 0x10, 0x14, 0x18, 0x1C and 0x20 have no effect, and those words keep reading their R1 values.
- R4: Any other address in the 0x400-byte window reads 0 and ignores writes. This includes addresses that are not word-aligned.
- R5: The status word has RXNE in bit 0, TXE in bit 1 and BSY in bit 7. Bit 3 always reads 1, and every other bit reads 0.
- R6: With bits 6 and 2 of 0x00 both set, a write to 0x0C at once gives TXE=0 and BSY=1. When the exchange completes, BSY=0, TXE=1 and RXNE=1, so the status word reads 0x0000000B.
- R7: If bit 6 or bit 2 of 0x00 is clear, a data write only loads the transmit buffer. TXE reads 0, BSY reads 0 and SCK stays low. The exchange of that byte starts once both bits are set.
- R8: A frame is 8 bits, sent MSB first in mode 0. MOSI changes only on SCK falling edges, and MISO is sampled on rising edges. A read of 0x0C returns the byte received in the last exchange.
- R9: Each exchange gives exactly 8 SCK pulses with a period of CLK_DIV system clocks, each high for CLK_DIV/2 clocks. SCK idles low.
- R10: A read of 0x0C clears RXNE.
- R11: A write to 0x0C while BSY reads 1 is ignored. The byte in flight and the byte sent next are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address inside the window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |

## Verification
The bench sweeps all 256 transmit bytes and pairs each with a different slave reply. A bit-order or sampling-edge error shows up as a mirrored or shifted byte, either on MOSI or in the received data. Each exchange counts SCK pulses and high cycles, so an off-by-one in the divider or in the bit counter changes the counts. The bench also loads a byte while the block is disabled, where a design that starts anyway would toggle SCK early. It writes again mid-exchange, where a design that accepts the write would corrupt the frame on the wire. Stray writes to the read-only and dummy words, and to unmapped or misaligned addresses, must leave every readback at its reset value.

// File: rtl/spi_master_pkg.sv
package spi_master_pkg;
  localparam int unsigned REG_W = 32;

  localparam int unsigned OFF_CFG_A    = 'h00;
  localparam int unsigned OFF_CFG_B    = 'h04;
  localparam int unsigned OFF_STAT     = 'h08;
  localparam int unsigned OFF_DATA     = 'h0C;
  localparam int unsigned OFF_POLY     = 'h10;
  localparam int unsigned OFF_SUM_RX   = 'h14;
  localparam int unsigned OFF_SUM_TX   = 'h18;
  localparam int unsigned OFF_AUD_CFG  = 'h1C;
  localparam int unsigned OFF_AUD_DIV  = 'h20;

  localparam logic [REG_W-1:0] RST_DATA    = 32'h0000_000C;
  localparam logic [REG_W-1:0] RST_POLY    = 32'h0000_0007;
  localparam logic [REG_W-1:0] RST_AUD_DIV = 32'h0000_0002;

  localparam int unsigned EN_BIT  = 6;
  localparam int unsigned MST_BIT = 2;
endpackage

// File: rtl/spi_master_shift.sv
module spi_master_shift #(
  parameter int unsigned FRAME_W = 8,
  parameter int unsigned CLK_DIV = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [FRAME_W-1:0] tx_byte_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [FRAME_W-1:0] rx_byte_o,
  output logic               sck_o,
  output logic               mosi_o,
  input  logic               miso_i
);
  localparam int unsigned HALF = CLK_DIV / 2;
  localparam int unsigned CW   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int unsigned BW   = (FRAME_W > 1) ? $clog2(FRAME_W) : 1;

  logic               busy_q, sck_q;
  logic [CW-1:0]      div_q;
  logic [BW-1:0]      bit_q;
  logic [FRAME_W-1:0] tx_sh_q, rx_sh_q;
  logic               tick, last;

  assign tick   = div_q == CW'(HALF - 1);
  assign last   = bit_q == BW'(FRAME_W - 1);
  assign done_o = busy_q & tick & sck_q & last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      sck_q   <= 1'b0;
      div_q   <= '0;
      bit_q   <= '0;
      tx_sh_q <= '0;
      rx_sh_q <= '0;
    end else if (start_i && !busy_q) begin
      busy_q  <= 1'b1;
      sck_q   <= 1'b0;
      div_q   <= '0;
      bit_q   <= '0;
      tx_sh_q <= tx_byte_i;
    end else if (busy_q) begin
      if (tick) begin
        div_q <= '0;
        if (!sck_q) begin
          sck_q   <= 1'b1;
          rx_sh_q <= {rx_sh_q[FRAME_W-2:0], miso_i};
        end else begin
          sck_q <= 1'b0;
          if (last) busy_q <= 1'b0;
          else begin
            bit_q   <= bit_q + 1'b1;
            tx_sh_q <= {tx_sh_q[FRAME_W-2:0], 1'b0};
          end
        end
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end

  assign busy_o    = busy_q;
  assign sck_o     = sck_q;
  assign mosi_o    = busy_q & tx_sh_q[FRAME_W-1];
  assign rx_byte_o = rx_sh_q;

  AST_SCK_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> !sck_q); // R9
  AST_DONE_ENDS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_q); // R6
  AST_MOSI_HOLD_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && sck_q && $past(sck_q)) |-> $stable(mosi_o)); // R8
endmodule

// File: rtl/spi_master_regs.sv
module spi_master_regs
  import spi_master_pkg::*;
#(
  parameter int unsigned ADDR_W  = 10,
  parameter int unsigned FRAME_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [REG_W-1:0]   wdata_i,
  output logic [REG_W-1:0]   rdata_o,
  input  logic               eng_busy_i,
  input  logic               done_i,
  input  logic [FRAME_W-1:0] rx_byte_i,
  output logic               start_o,
  output logic [FRAME_W-1:0] tx_byte_o,
  output logic               en_o
);
  logic [REG_W-1:0]   cfg_a_q, cfg_b_q;
  logic [FRAME_W-1:0] tx_buf_q, rx_buf_q;
  logic               tx_full_q, rxne_q;
  logic               bsy, txe, wr, rd, hit_data;

  assign wr       = req_i & we_i;
  assign rd       = req_i & ~we_i;
  assign hit_data = addr_i == ADDR_W'(OFF_DATA);
  assign en_o     = cfg_a_q[EN_BIT] & cfg_a_q[MST_BIT];
  assign bsy      = eng_busy_i | (tx_full_q & en_o);
  assign txe      = ~(tx_full_q | eng_busy_i);
  assign start_o  = tx_full_q & en_o & ~eng_busy_i;
  assign tx_byte_o = tx_buf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_a_q   <= '0;
      cfg_b_q   <= '0;
      tx_buf_q  <= '0;
      tx_full_q <= 1'b0;
      rx_buf_q  <= FRAME_W'(RST_DATA);
      rxne_q    <= 1'b0;
    end else begin
      if (wr && addr_i == ADDR_W'(OFF_CFG_A)) cfg_a_q <= wdata_i;
      if (wr && addr_i == ADDR_W'(OFF_CFG_B)) cfg_b_q <= wdata_i;
      if (wr && hit_data && !bsy) begin
        tx_buf_q  <= wdata_i[FRAME_W-1:0];
        tx_full_q <= 1'b1;
      end else if (start_o) begin
        tx_full_q <= 1'b0;
      end
      if (done_i) begin
        rx_buf_q <= rx_byte_i;
        rxne_q   <= 1'b1;
      end else if (rd && hit_data) begin
        rxne_q <= 1'b0;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(OFF_CFG_A))        rdata_o = cfg_a_q;
    else if (addr_i == ADDR_W'(OFF_CFG_B))   rdata_o = cfg_b_q;
    else if (addr_i == ADDR_W'(OFF_STAT))    rdata_o = REG_W'({bsy, 3'b000, 1'b1, 1'b0, txe, rxne_q});
    else if (hit_data)                       rdata_o = REG_W'(rx_buf_q);
    else if (addr_i == ADDR_W'(OFF_POLY))    rdata_o = RST_POLY;
    else if (addr_i == ADDR_W'(OFF_AUD_DIV)) rdata_o = RST_AUD_DIV;
  end

  AST_RXNE_ON_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> rxne_q); // R6
  AST_READ_CLEARS_RXNE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && hit_data && !done_i) |=> !rxne_q); // R10
  AST_BUSY_WRITE_DROPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && hit_data && bsy) |=> $stable(tx_buf_q)); // R11
endmodule

// File: rtl/spi_master_ctrl.sv
module spi_master_ctrl
  import spi_master_pkg::*;
#(
  parameter int unsigned ADDR_W  = 10,
  parameter int unsigned FRAME_W = 8,
  parameter int unsigned CLK_DIV = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              sck_o,
  output logic              mosi_o,
  input  logic              miso_i
);
  logic               start, eng_busy, done, en;
  logic [FRAME_W-1:0] tx_byte, rx_byte;

  spi_master_regs #(.ADDR_W(ADDR_W), .FRAME_W(FRAME_W)) u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o,
    .eng_busy_i(eng_busy), .done_i(done), .rx_byte_i(rx_byte),
    .start_o(start), .tx_byte_o(tx_byte), .en_o(en)
  );

  spi_master_shift #(.FRAME_W(FRAME_W), .CLK_DIV(CLK_DIV)) u_shift (
    .clk_i, .rst_ni, .start_i(start), .tx_byte_i(tx_byte),
    .busy_o(eng_busy), .done_o(done), .rx_byte_o(rx_byte),
    .sck_o, .mosi_o, .miso_i
  );

  AST_RUN_NEEDS_ENABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(eng_busy) |-> $past(en)); // R7
endmodule

// File: tb/spi_master_ctrl_tb.sv
`timescale 1ns/1ps
module spi_master_ctrl_tb;
  localparam int unsigned ADDR_W  = 10;
  localparam int unsigned CLK_DIV = 4;
  localparam int unsigned WD_LIM  = 150000;

  logic              clk = 1'b0, rst_n = 1'b0;
  logic              req = 1'b0, we = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0]       wdata = '0, rdata;
  logic              sck, mosi, miso;

  int vectors = 0, errors = 0, cycles = 0, hi_cnt = 0, pulses = 0;
  logic [7:0] slave_sh = '0, mcap = '0;

  always #2 clk = ~clk;

  spi_master_ctrl #(.ADDR_W(ADDR_W), .FRAME_W(8), .CLK_DIV(CLK_DIV)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .sck_o(sck), .mosi_o(mosi), .miso_i(miso)
  );

  // slave model: mode 0, MSB first
  assign miso = slave_sh[7];
  always @(posedge sck) begin mcap <= {mcap[6:0], mosi}; pulses <= pulses + 1; end
  always @(negedge sck) slave_sh <= {slave_sh[6:0], 1'b0};
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (sck) hi_cnt <= hi_cnt + 1;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int unsigned a, input logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = ADDR_W'(a); wdata = d;
    @(negedge clk); req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input int unsigned a, output logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = ADDR_W'(a);
    #1 d = rdata;
    @(negedge clk); req = 1'b0;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    bit done = 0;
    for (int k = 0; k < 300 && !done; k++) begin
      rd('h08, s);
      if (!s[7]) done = 1;
    end
    check("R6 idle reached", 32'(done), 32'd1);
  endtask

  task automatic xfer(input logic [7:0] tx, input logic [7:0] sl);
    logic [31:0] v;
    slave_sh = sl; pulses = 0; hi_cnt = 0;
    wr('h0C, 32'(tx));
    rd('h08, v);
    check("R6 busy after write", v, 32'h88);
    wait_idle();
    rd('h08, v);
    check("R6 status after done", v, 32'h0B);
    check("R8 mosi byte", 32'(mcap), 32'(tx));
    check("R9 pulse count", pulses, 8);
    check("R9 high cycles", hi_cnt, 8 * (CLK_DIV / 2));
    rd('h0C, v);
    check("R8 received byte", v, 32'(sl));
    rd('h08, v);
    check("R10 rxne cleared", v, 32'h0A);
  endtask

  initial begin
    wait (cycles >= WD_LIM);
    errors++;
    $display("FAIL watchdog act=%0d exp<%0d", cycles, WD_LIM);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values, R5 status layout
    rd('h00, v); check("R1 cfg_a", v, 0);
    rd('h04, v); check("R1 cfg_b", v, 0);
    rd('h08, v); check("R1 R5 status", v, 32'h0A);
    rd('h0C, v); check("R1 data", v, 32'h0C);
    rd('h10, v); check("R1 poly", v, 32'h07);
    rd('h14, v); check("R1 sum_rx", v, 0);
    rd('h18, v); check("R1 sum_tx", v, 0);
    rd('h1C, v); check("R1 aud_cfg", v, 0);
    rd('h20, v); check("R1 aud_div", v, 32'h02);

    // R3 ignored writes
    wr('h08, 32'hFFFF_FFFF); rd('h08, v); check("R3 status", v, 32'h0A);
    wr('h10, 32'hFFFF_FFFF); rd('h10, v); check("R3 poly", v, 32'h07);
    wr('h14, 32'hFFFF_FFFF); rd('h14, v); check("R3 sum_rx", v, 0);
    wr('h18, 32'hFFFF_FFFF); rd('h18, v); check("R3 sum_tx", v, 0);
    wr('h1C, 32'hFFFF_FFFF); rd('h1C, v); check("R3 aud_cfg", v, 0);
    wr('h20, 32'hFFFF_FFFF); rd('h20, v); check("R3 aud_div", v, 32'h02);

    // R4 unmapped and misaligned
    wr('h24, 32'hDEAD_BEEF); rd('h24, v); check("R4 unmapped 0x24", v, 0);
    wr('h3FC, 32'hDEAD_BEEF); rd('h3FC, v); check("R4 unmapped 0x3FC", v, 0);
    wr('h01, 32'hFFFF_FFFF); rd('h01, v); check("R4 misaligned", v, 0);
    rd('h00, v); check("R4 cfg_a untouched", v, 0);

    // R2 readback
    wr('h04, 32'hA5C3_0F1E); rd('h04, v); check("R2 cfg_b", v, 32'hA5C3_0F1E);

    // R7 master only: load, no start
    wr('h00, 32'h04); rd('h00, v); check("R2 cfg_a", v, 32'h04);
    slave_sh = 8'h96; pulses = 0; hi_cnt = 0;
    wr('h0C, 32'h5A);
    repeat (40) @(negedge clk);
    rd('h08, v); check("R7 pending status", v, 32'h08);
    check("R7 no sck", pulses, 0);
    wr('h00, 32'h44);
    wait_idle();
    check("R7 late mosi", 32'(mcap), 32'h5A);
    rd('h0C, v); check("R7 late rx", v, 32'h96);
    check("R9 late pulses", pulses, 8);

    // R11 write while busy
    slave_sh = 8'h21; pulses = 0;
    wr('h0C, 32'h3C);
    wr('h0C, 32'hC3);
    wait_idle();
    check("R11 mosi kept", 32'(mcap), 32'h3C);
    check("R11 pulses", pulses, 8);
    rd('h08, v); check("R11 no pending", v, 32'h0B);
    rd('h0C, v); check("R11 rx", v, 32'h21);

    // R8 R9 R10 full sweep
    for (int i = 0; i < 256; i++) xfer(8'(i), 8'(i * 37 + 11));

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule